// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens passively to the two lines of an open-drain I2C bus and tells a controller what is happening on it. Both lines first pass through a two-flop synchronizer. The block then compares each synchronized sample with the one before it to find edges. When SDA changes while SCL is high, the change is not data. A falling SDA marks a START and a rising SDA marks a STOP. Each event comes out as a single-cycle pulse.

A small state machine tracks bus ownership and drives a `busy` level. Multi-master logic can test this level before it tries to claim the bus. A START on a free bus is reported as a first START. A START while the bus is already claimed is reported as a repeated START, and it leaves `busy` set. Only a STOP frees the bus.

After every START or repeated START, the block also shifts in the first byte, MSB first, sampling on each rising SCL. If that byte is the start-byte marker, it raises a flag. Listeners that sample the bus slowly use this marker to notice bus activity.

The machine has three states:
- `MON_IDLE`: the bus is free.
- `MON_HEAD`: the bus is claimed and the first byte is being collected.
- `MON_BODY`: the bus is claimed and the first byte is complete.

Its transitions are:
- `IDLE→HEAD` on START.
- `HEAD→HEAD` and `BODY→HEAD` on a repeated START, which also restarts the bit count.
- `HEAD→BODY` on the eighth SCL rise.
- `HEAD→IDLE` and `BODY→IDLE` on STOP.
- `IDLE→IDLE` on a stray STOP.

Top module: `i2c_bus_watch`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy` is 0 and all four event outputs are 0.
- R2: An SDA fall on a free bus, with SCL held high, raises `start_evt` for exactly one cycle. It sets `busy`. The pulse is visible after the third rising clock edge that follows the change of `sda_in`.
- R3: An SDA rise while SCL is high and the bus is claimed raises `stop_evt` for one cycle, and `busy` returns to 0.
- R4: An SDA fall with SCL high while `busy` is 1 raises `restart_evt` and not `start_evt`, and `busy` stays 1.
- R5: SDA changes made while SCL is low raise no event and leave `busy` unchanged.
- R6: After a START or a repeated START, the block samples SDA on each of the next eight SCL rises, MSB first. If the byte equals 8'h01, `startbyte_evt` pulses once, one cycle after the eighth rise is detected.
- R7: A first byte other than 8'h01 gives no `startbyte_evt`. Bytes after the first byte of a transfer never give `startbyte_evt`.
- R8: A repeated START in the middle of a byte discards the bits collected so far, and collection restarts from bit 0.
- R9: A STOP seen on a free bus still pulses `stop_evt`, and `busy` stays 0.
- R10: At most one event output is 1 in any cycle, and no event stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the bus pad |
| sda_in | input | 1 | Raw SDA level from the bus pad |
| start_evt | output | 1 | One-cycle pulse: START on a free bus |
| restart_evt | output | 1 | One-cycle pulse: START while the bus is claimed |
| stop_evt | output | 1 | One-cycle pulse: STOP seen |
| startbyte_evt | output | 1 | One-cycle pulse: first byte after a START was 8'h01 |
| busy | output | 1 | High from START until STOP |

## Verification
The state machine itself drives `busy`, so a wrong state shows at the ports on the very next cycle. A wrong state also flips the next START between `start_evt` and `restart_evt`. A corrupted bit count or shift register shows only at the end of the first byte: `startbyte_evt` is then missing, spurious, or arrives after the wrong SCL rise, up to eight bit periods after the fault. The bench checks the three-edge latency exactly and counts pulses per scenario, so a lost, doubled or stretched event is caught.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    typedef enum logic [1:0] {
        MON_IDLE = 2'd0,
        MON_HEAD = 2'd1,
        MON_BODY = 2'd2
    } mon_state_t;

    typedef struct packed {
        logic start_c;
        logic stop_c;
        logic scl_up;
        logic sda_now;
    } bus_cond_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);
    // Idle bus rests high, so every stage resets to 1.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
            end
        end
        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_watch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_s,
    input  logic      sda_s,
    output bus_cond_t cond_o
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    logic scl_hold_high;
    assign scl_hold_high = scl_s & scl_p;

    always_comb begin
        cond_o.start_c = scl_hold_high & sda_p & ~sda_s;
        cond_o.stop_c  = scl_hold_high & ~sda_p & sda_s;
        cond_o.scl_up  = scl_s & ~scl_p;
        cond_o.sda_now = sda_s;
    end
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_i,
    input  logic              bit_i,
    output logic              last_o,
    output logic [BYTE_W-1:0] word_o
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            shf_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
            shf_q <= '0;
        end else if (take_i) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
            shf_q <= word_o;
        end
    end

    // Word as it will be once the current bit is shifted in (MSB first).
    assign word_o = {shf_q[BYTE_W-2:0], bit_i};
    assign last_o = take_i && (cnt_q == LAST_IDX);
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          BYTE_W      = 8,
    parameter logic [7:0]  MARK_BYTE   = 8'h01
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_evt,
    output logic restart_evt,
    output logic stop_evt,
    output logic startbyte_evt,
    output logic busy
);
    localparam logic [BYTE_W-1:0] MARK = BYTE_W'(MARK_BYTE);

    logic [1:0] sync_w;
    bus_cond_t  cond;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_in, sda_in}),
        .sync_o (sync_w)
    );

    i2c_cond_detect u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (sync_w[1]),
        .sda_s  (sync_w[0]),
        .cond_o (cond)
    );

    mon_state_t        state_q, state_d;
    logic              clr_w, take_w, last_w;
    logic [BYTE_W-1:0] word_w;
    logic              start_d, restart_d, stop_d, mark_d;

    assign take_w = cond.scl_up && (state_q == MON_HEAD);

    i2c_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_w),
        .take_i (take_w),
        .bit_i  (cond.sda_now),
        .last_o (last_w),
        .word_o (word_w)
    );

    // Next state and event decode.
    always_comb begin
        state_d   = state_q;
        clr_w     = 1'b0;
        start_d   = 1'b0;
        restart_d = 1'b0;
        stop_d    = 1'b0;
        mark_d    = 1'b0;
        unique case (state_q)
            MON_IDLE: begin
                if (cond.start_c) begin
                    state_d = MON_HEAD;
                    start_d = 1'b1;
                    clr_w   = 1'b1;
                end else if (cond.stop_c) begin
                    stop_d  = 1'b1;
                end
            end
            MON_HEAD: begin
                if (cond.stop_c) begin
                    state_d = MON_IDLE;
                    stop_d  = 1'b1;
                end else if (cond.start_c) begin
                    restart_d = 1'b1;
                    clr_w     = 1'b1;
                end else if (last_w) begin
                    state_d = MON_BODY;
                    mark_d  = (word_w == MARK);
                end
            end
            MON_BODY: begin
                if (cond.stop_c) begin
                    state_d = MON_IDLE;
                    stop_d  = 1'b1;
                end else if (cond.start_c) begin
                    state_d   = MON_HEAD;
                    restart_d = 1'b1;
                    clr_w     = 1'b1;
                end
            end
            default: begin
                state_d = MON_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_evt     <= 1'b0;
            restart_evt   <= 1'b0;
            stop_evt      <= 1'b0;
            startbyte_evt <= 1'b0;
        end else begin
            start_evt     <= start_d;
            restart_evt   <= restart_d;
            stop_evt      <= stop_d;
            startbyte_evt <= mark_d;
        end
    end

    assign busy = (state_q != MON_IDLE);
endmodule

// File: rtl/i2c_bus_watch_chk.sv
module i2c_bus_watch_chk (
    input logic clk,
    input logic rst_n,
    input logic start_evt,
    input logic restart_evt,
    input logic stop_evt,
    input logic startbyte_evt,
    input logic busy
);
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, restart_evt, stop_evt, startbyte_evt})); // R10
    AST_SHORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || restart_evt || stop_evt || startbyte_evt) |=>
        !(start_evt || restart_evt || stop_evt || startbyte_evt)); // R10
    AST_START_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |-> busy && !$past(busy)); // R2
    AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_evt |-> busy && $past(busy)); // R4
    AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |-> !busy); // R3
    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_evt); // R2
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> stop_evt); // R3
    AST_MARK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        startbyte_evt |-> busy && $past(busy)); // R6
endmodule

bind i2c_bus_watch i2c_bus_watch_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_evt     (start_evt),
    .restart_evt   (restart_evt),
    .stop_evt      (stop_evt),
    .startbyte_evt (startbyte_evt),
    .busy          (busy)
);

// File: tb/i2c_bus_watch_bench.sv
module i2c_bus_watch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1;
    logic sda_r = 1'b1;
    logic start_evt, restart_evt, stop_evt, startbyte_evt, busy;

    int n_chk = 0;
    int n_bad = 0;
    int c_start = 0, c_rstart = 0, c_stop = 0, c_mark = 0;
    int c_multi = 0, c_long = 0;
    logic any_prev = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_watch u_i2c_bus_watch (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl_r),
        .sda_in        (sda_r),
        .start_evt     (start_evt),
        .restart_evt   (restart_evt),
        .stop_evt      (stop_evt),
        .startbyte_evt (startbyte_evt),
        .busy          (busy)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int n;
            n = int'(start_evt) + int'(restart_evt) + int'(stop_evt) + int'(startbyte_evt);
            if (start_evt)     c_start++;
            if (restart_evt)   c_rstart++;
            if (stop_evt)      c_stop++;
            if (startbyte_evt) c_mark++;
            if (n > 1) c_multi++;
            if (n > 0 && any_prev) c_long++;
            any_prev = (n > 0);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        c_start = 0; c_rstart = 0; c_stop = 0; c_mark = 0;
    endtask

    task automatic bus(input logic s, input logic d);
        @(negedge clk);
        scl_r = s;
        sda_r = d;
        repeat (HALF_BIT) @(negedge clk);
    endtask

    task automatic do_start();
        bus(1'b0, 1'b1);
        bus(1'b1, 1'b1);
        bus(1'b1, 1'b0);
        bus(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b0);
        bus(1'b1, 1'b1);
    endtask

    task automatic send_bit(input logic b);
        bus(1'b0, b);
        bus(1'b1, b);
        bus(1'b0, b);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic t_reset();
        check("R1 busy in reset", int'(busy), 0);
        check("R1 events in reset", int'(start_evt | restart_evt | stop_evt | startbyte_evt), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy), 0);
        check("R1 events after reset", int'(start_evt | restart_evt | stop_evt | startbyte_evt), 0);
    endtask

    task automatic t_start_latency();
        clear_counts();
        @(negedge clk);
        sda_r = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2 no pulse after two edges", int'(start_evt), 0);
        @(negedge clk);
        check("R2 pulse after third edge", int'(start_evt), 1);
        check("R2 busy set", int'(busy), 1);
        @(negedge clk);
        check("R2 pulse one cycle", int'(start_evt), 0);
        bus(1'b0, 1'b0);
        check("R2 single start", c_start, 1);
        check("R2 no restart", c_rstart, 0);
    endtask

    task automatic t_stop();
        clear_counts();
        do_stop();
        check("R3 one stop", c_stop, 1);
        check("R3 busy cleared", int'(busy), 0);
    endtask

    task automatic t_low_changes();
        do_start();
        clear_counts();
        bus(1'b0, 1'b1);
        bus(1'b0, 1'b0);
        bus(1'b0, 1'b1);
        bus(1'b0, 1'b0);
        check("R5 no events", c_start + c_rstart + c_stop + c_mark, 0);
        check("R5 busy kept", int'(busy), 1);
        do_stop();
    endtask

    task automatic t_restart();
        do_start();
        send_byte(8'hA4);
        send_bit(1'b0);
        clear_counts();
        do_start();
        check("R4 restart pulse", c_rstart, 1);
        check("R4 no start pulse", c_start, 0);
        check("R4 busy stays", int'(busy), 1);
        do_stop();
    endtask

    task automatic t_mark();
        do_start();
        clear_counts();
        send_byte(8'h01);
        check("R6 start byte seen", c_mark, 1);
        send_bit(1'b1);
        do_stop();
        check("R6 no extra mark", c_mark, 1);
    endtask

    task automatic t_other();
        do_start();
        clear_counts();
        send_byte(8'h81);
        check("R7 other first byte", c_mark, 0);
        send_bit(1'b0);
        send_byte(8'h01);
        check("R7 second byte ignored", c_mark, 0);
        do_stop();
    endtask

    task automatic t_mid_restart();
        do_start();
        send_bit(1'b0);
        send_bit(1'b0);
        send_bit(1'b0);
        clear_counts();
        do_start();
        send_byte(8'h01);
        check("R8 count restarted", c_mark, 1);
        do_stop();
    endtask

    task automatic t_stray_stop();
        clear_counts();
        do_stop();
        check("R9 stray stop pulse", c_stop, 1);
        check("R9 busy stays low", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        repeat (4) @(negedge clk);
        t_start_latency();
        t_stop();
        t_low_changes();
        t_restart();
        t_mark();
        t_other();
        t_mid_restart();
        t_stray_stop();
        check("R10 overlapping events", c_multi, 0);
        check("R10 stretched events", c_long, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule